// File: doc/BRIEF.md
# Ethernet Transmit Frame Serializer

This block takes a frame as a stream of bytes and puts it on a single serial output line, one bit per clock. The bytes arrive in order: destination address, then source address, then length or type field, then payload. The length field must be supplied most significant byte first. Before the first input byte goes out, the block sends a preamble of seven alternating-bit bytes and a start delimiter. Every byte leaves least significant bit first. After the last input byte, the block adds zero bytes until header plus data reach the minimum frame size. It then adds a four-byte CRC-32 frame check sequence.

A per-frame control input turns CRC insertion off. In that case the input stream passes through unchanged after the delimiter. This covers the case where the upstream logic already carries its own check sequence in its last four bytes. No padding is added in that mode. The input handshake is valid/ready with a last flag. The block takes at most one byte per eight bit times. If the source falls behind, the serial output pauses at a byte boundary until the next byte arrives. A single-cycle end-of-frame pulse marks the final bit. Medium access, collision handling and interframe spacing are left to the surrounding logic.

Top module: `eth_tx_framer`

## Requirements
- R1: During and just after reset, `ser_valid`, `in_ready` and `eof` are all low.
- R2: A frame starts only when `in_valid` is high while the block is idle. It begins with 56 bits alternating 1,0,… (first bit 1), then the eight delimiter bits 1,0,1,0,1,0,1,1. `ser_valid` stays high without a break throughout.
- R3: Input bytes go out directly after the delimiter, in arrival order, each least significant bit first. `in_ready` is high only in the cycle carrying the last bit of a byte, or while the output is paused waiting for data. At most one byte is taken per 8 bit times.
- R4: `in_ready` stays low while preamble, delimiter, pad or check-sequence bytes are being loaded. It also stays low after the byte flagged `in_last` has been taken.
- R5: With CRC insertion on, if fewer than 60 bytes (14 header plus 46 data) were received, zero-valued pad bytes follow until 60 bytes have been sent. A frame of 60 or more bytes gets no pad.
- R6: With CRC insertion on, four check bytes follow the data and pad. They hold the complement of the reflected CRC-32 (polynomial 0xEDB88320, register preset to all ones) over every byte from the first header byte through the last pad byte. They are sent low byte first, each least significant bit first.
- R7: `crc_off` is sampled when a frame starts and holds for the whole frame. When it is 1, the frame ends right after the last input byte, with no pad and no check bytes.
- R8: `eof` pulses for exactly one cycle, together with the final serial bit of the frame. `ser_valid` is low in the following cycle.
- R9: If no byte is offered when one is needed, `ser_valid` drops at the byte boundary and stays low until a byte arrives. Output then resumes with nothing lost or repeated. A pause never splits a byte.
- R10: A new frame may start in the cycle right after the previous frame's `eof` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| crc_off | input | 1 | 1: send the stream as is, no pad, no CRC (sampled at frame start) |
| in_data | input | 8 | Frame byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | Current byte is the last one of the frame |
| in_ready | output | 1 | Block takes the byte in this cycle if `in_valid` is high |
| ser_bit | output | 1 | Serial data bit |
| ser_valid | output | 1 | `ser_bit` carries a frame bit |
| eof | output | 1 | Final bit of the frame is on `ser_bit` |

## Verification
A wrong phase or byte counter shows up as a misplaced or missing preamble, pad or check byte. That error appears within eight bit times of the byte concerned, and it also moves the `eof` pulse away from the final bit. A wrong CRC register shows only in the last 32 bits of a CRC-enabled frame, so every such frame is compared bit for bit against a CRC computed independently. A mis-timed handshake shows up at once: `in_ready` is high in a cycle that does not end a byte, or during preamble, pad or check bytes. A stalled source must produce a clean pause, with no lost or repeated bits.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_SFD,
    PH_DATA,
    PH_PAD,
    PH_FCS
  } phase_e;

  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;

  // One byte through a bit-reflected CRC, data taken LSB first.
  function automatic logic [31:0] crc_step(input logic [31:0] c_in,
                                           input logic [7:0]  b,
                                           input logic [31:0] poly_r);
    logic [31:0] r;
    r = c_in;
    for (int i = 0; i < 8; i++) begin
      r = (r[0] ^ b[i]) ? ((r >> 1) ^ poly_r) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_tx_crc32.sv
module eth_tx_crc32 #(
  parameter int unsigned         CW     = 32,
  parameter logic [CW-1:0]       POLY_R = 32'hEDB88320,
  parameter int unsigned         BW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          upd,
  input  logic [BW-1:0] upd_byte,
  input  logic          shift,
  output logic [CW-1:0] crc_q
);
  import eth_tx_pkg::*;

  logic [CW-1:0] crc_d;

  always_comb begin
    crc_d = crc_q;
    if (init)       crc_d = '1;
    else if (upd)   crc_d = crc_step(crc_q, upd_byte, POLY_R);
    else if (shift) crc_d = crc_q >> BW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '1;
    else        crc_q <= crc_d;
  end

  // R6: at most one operation on the register per cycle
  a_r6_exclusive_ops: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd && shift) && !(init && shift) && !(init && upd));

endmodule

// File: rtl/eth_tx_ser.sv
module eth_tx_ser #(
  parameter int unsigned BW = 8,
  localparam int unsigned NW = $clog2(BW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] din,
  output logic          bit_out,
  output logic          act,
  output logic          last_bit,
  output logic          need
);

  logic [BW-1:0] sh_q, sh_d;
  logic [NW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  assign last_bit = act_q && (cnt_q == NW'(BW - 1));
  assign need     = !act_q || (cnt_q == NW'(BW - 1));
  assign bit_out  = sh_q[0];
  assign act      = act_q;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    act_d = act_q;
    if (load) begin
      sh_d  = din;
      cnt_d = '0;
      act_d = 1'b1;
    end else if (act_q) begin
      if (cnt_q == NW'(BW - 1)) begin
        act_d = 1'b0;
      end else begin
        sh_d  = sh_q >> 1;
        cnt_d = cnt_q + NW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  // R3: a new byte is only loaded at a byte boundary
  a_r3_load_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> need);

  // R9: output never pauses inside a byte
  a_r9_no_midbyte_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q != NW'(BW - 1)) |=> (act_q && cnt_q == $past(cnt_q) + NW'(1)));

endmodule

// File: rtl/eth_tx_seq.sv
module eth_tx_seq #(
  parameter int unsigned BW      = 8,
  parameter int unsigned PRE_LEN = 7,
  parameter int unsigned MIN_LEN = 60,
  parameter int unsigned FCS_LEN = 4,
  parameter int unsigned CW      = 32,
  localparam int unsigned KMAX   = (PRE_LEN > FCS_LEN) ? PRE_LEN : FCS_LEN,
  localparam int unsigned KW     = $clog2(KMAX + 1),
  localparam int unsigned LW     = $clog2(MIN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          crc_off,
  input  logic [BW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_last,
  output logic          in_ready,
  input  logic          need,
  input  logic          last_bit,
  input  logic [CW-1:0] crc_q,
  output logic          load,
  output logic [BW-1:0] din,
  output logic          crc_init,
  output logic          crc_upd,
  output logic [BW-1:0] crc_byte,
  output logic          crc_shift,
  output logic          eof
);
  import eth_tx_pkg::*;

  phase_e        phase_q, phase_d;
  logic [KW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] len_q, len_d;
  logic          last_q, last_d;
  logic          nocrc_q, nocrc_d;

  logic [LW-1:0] len_inc;
  assign len_inc = (len_q == LW'(MIN_LEN)) ? len_q : len_q + LW'(1);

  assign eof = last_bit &&
               ((phase_q == PH_FCS && cnt_q == KW'(FCS_LEN - 1)) ||
                (phase_q == PH_DATA && last_q && nocrc_q));

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    len_d     = len_q;
    last_d    = last_q;
    nocrc_d   = nocrc_q;
    load      = 1'b0;
    din       = '0;
    in_ready  = 1'b0;
    crc_init  = 1'b0;
    crc_upd   = 1'b0;
    crc_byte  = '0;
    crc_shift = 1'b0;

    if (need) begin
      unique case (phase_q)
        PH_IDLE: begin
          if (in_valid) begin
            load     = 1'b1;
            din      = PRE_BYTE;
            phase_d  = PH_PRE;
            cnt_d    = KW'(1);
            len_d    = '0;
            last_d   = 1'b0;
            nocrc_d  = crc_off;
            crc_init = 1'b1;
          end
        end
        PH_PRE: begin
          load = 1'b1;
          if (cnt_q == KW'(PRE_LEN)) begin
            din     = SFD_BYTE;
            phase_d = PH_SFD;
          end else begin
            din   = PRE_BYTE;
            cnt_d = cnt_q + KW'(1);
          end
        end
        PH_SFD, PH_DATA, PH_PAD: begin
          if (phase_q != PH_PAD && !(phase_q == PH_DATA && last_q)) begin
            in_ready = 1'b1;
            if (in_valid) begin
              load     = 1'b1;
              din      = in_data;
              phase_d  = PH_DATA;
              last_d   = in_last;
              crc_upd  = 1'b1;
              crc_byte = in_data;
              len_d    = len_inc;
            end
          end else if (nocrc_q) begin
            phase_d = PH_IDLE;
          end else if (len_q < LW'(MIN_LEN)) begin
            load     = 1'b1;
            din      = '0;
            phase_d  = PH_PAD;
            crc_upd  = 1'b1;
            crc_byte = '0;
            len_d    = len_inc;
          end else begin
            load      = 1'b1;
            din       = ~crc_q[BW-1:0];
            crc_shift = 1'b1;
            phase_d   = PH_FCS;
            cnt_d     = '0;
          end
        end
        PH_FCS: begin
          if (cnt_q == KW'(FCS_LEN - 1)) begin
            phase_d = PH_IDLE;
          end else begin
            load      = 1'b1;
            din       = ~crc_q[BW-1:0];
            crc_shift = 1'b1;
            cnt_d     = cnt_q + KW'(1);
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      last_q  <= 1'b0;
      nocrc_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      last_q  <= last_d;
      nocrc_q <= nocrc_d;
    end
  end

  // R5: byte count used for padding never runs past the minimum
  a_r5_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LW'(MIN_LEN));

  // R7: the CRC mode chosen at frame start holds for the whole frame
  a_r7_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && phase_d != PH_IDLE) |=> $stable(nocrc_q));

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer #(
  parameter int unsigned BW      = 8,
  parameter int unsigned PRE_LEN = 7,
  parameter int unsigned MIN_LEN = 60,
  parameter int unsigned FCS_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          crc_off,
  input  logic [BW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_last,
  output logic          in_ready,
  output logic          ser_bit,
  output logic          ser_valid,
  output logic          eof
);
  localparam int unsigned CW = FCS_LEN * BW;

  logic          need, last_bit, load;
  logic [BW-1:0] din, crc_byte;
  logic          crc_init, crc_upd, crc_shift;
  logic [CW-1:0] crc_q;

  eth_tx_seq #(
    .BW(BW), .PRE_LEN(PRE_LEN), .MIN_LEN(MIN_LEN), .FCS_LEN(FCS_LEN), .CW(CW)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .crc_off(crc_off),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .need(need), .last_bit(last_bit), .crc_q(crc_q),
    .load(load), .din(din),
    .crc_init(crc_init), .crc_upd(crc_upd), .crc_byte(crc_byte), .crc_shift(crc_shift),
    .eof(eof)
  );

  eth_tx_ser #(.BW(BW)) i_ser (
    .clk(clk), .rst_n(rst_n), .load(load), .din(din),
    .bit_out(ser_bit), .act(ser_valid), .last_bit(last_bit), .need(need)
  );

  eth_tx_crc32 #(.CW(CW), .POLY_R(CW'(32'hEDB88320)), .BW(BW)) i_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .upd(crc_upd), .upd_byte(crc_byte),
    .shift(crc_shift), .crc_q(crc_q)
  );

  // R3: input is only taken at a byte boundary of the output
  a_r3_ready_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!ser_valid || last_bit));

  // R8: end-of-frame marks a real bit
  a_r8_eof_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> ser_valid);

  // R8: output goes quiet right after the final bit
  a_r8_quiet_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> !ser_valid);

endmodule

// File: tb/test_eth_tx_framer.sv
module test_eth_tx_framer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       crc_off;
  logic [7:0] in_data;
  logic       in_valid, in_last;
  logic       in_ready, ser_bit, ser_valid, eof;

  int n_tests = 0, n_fail = 0;
  bit exp_bits[$];
  bit exp_eof[$];
  int mism = 0, eof_bad = 0, ready_bad = 0, gap_cycles = 0;
  int frame_bits = 0, cur_n = 0;
  bit infrm = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_tx_framer i_eth_tx_framer (
    .clk(clk), .rst_n(rst_n), .crc_off(crc_off),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .ser_bit(ser_bit), .ser_valid(ser_valid), .eof(eof)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 29 + seed * 7 + 3) & 8'hff);
  endfunction

  // Monitor: compare every serial bit against the expected stream
  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_valid) begin
        infrm = 1;
        frame_bits++;
        if (exp_bits.size() == 0) mism++;
        else begin
          bit eb, ee;
          eb = exp_bits.pop_front();
          ee = exp_eof.pop_front();
          if (ser_bit !== eb) mism++;
          if (eof !== ee) eof_bad++;
        end
        if (eof) begin infrm = 0; frame_bits = 0; end
      end else begin
        if (infrm) gap_cycles++;
        if (eof) eof_bad++;
      end
      if (in_ready && !(frame_bits % 8 == 0 && frame_bits >= 64 &&
                        frame_bits <= 64 + 8 * (cur_n - 1)))
        ready_bad++;
    end
  end

  task automatic push_byte(input logic [7:0] b);
    for (int k = 0; k < 8; k++) begin
      exp_bits.push_back(b[k]);
      exp_eof.push_back(1'b0);
    end
  endtask

  task automatic build(input int n, input int seed, input bit nocrc);
    logic [31:0] c;
    int total;
    c = '1;
    for (int i = 0; i < 7; i++) push_byte(8'h55);
    push_byte(8'hD5);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = pat(i, seed);
      push_byte(b);
      for (int k = 0; k < 8; k++) c = (c[0] ^ b[k]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    total = n;
    if (!nocrc) begin
      while (total < 60) begin
        push_byte(8'h00);
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        total++;
      end
      c = ~c;
      for (int j = 0; j < 4; j++) push_byte(c[8*j +: 8]);
    end
    exp_eof[exp_eof.size() - 1] = 1'b1;
  endtask

  task automatic drive(input int n, input int seed, input bit nocrc,
                       input int gap, input bit flip_mode);
    cur_n   = n;
    crc_off = nocrc;
    for (int i = 0; i < n; i++) begin
      bit acc;
      in_data  = pat(i, seed);
      in_valid = 1'b1;
      in_last  = (i == n - 1);
      do begin
        acc = in_ready;
        @(negedge clk);
      end while (!acc);
      if (flip_mode && i == 3) crc_off = ~nocrc;
      if (gap > 0 && (i % 5) == 2 && i != n - 1) begin
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic drain;
    int t = 0;
    while (exp_bits.size() != 0 && t < 5000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic run_frame(input string rq, input int n, input int seed, input bit nocrc,
                           input int gap, input bit flip_mode, input bit expect_gap);
    int m0, e0, r0, g0;
    m0 = mism; e0 = eof_bad; r0 = ready_bad; g0 = gap_cycles;
    build(n, seed, nocrc);
    drive(n, seed, nocrc, gap, flip_mode);
    drain();
    chk(rq, "R2/R3/R6 bit mismatches", mism - m0, 0);
    chk(rq, "R8 eof misplaced", eof_bad - e0, 0);
    chk(rq, "R4 ready outside data slots", ready_bad - r0, 0);
    chk(rq, "leftover expected bits", exp_bits.size(), 0);
    if (expect_gap) chk(rq, "R9 pause seen", (gap_cycles - g0) > 0 ? 1 : 0, 1);
    else            chk(rq, "R2 continuous output", gap_cycles - g0, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; crc_off = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    chk("R1", "ser_valid in reset", int'(ser_valid), 0);
    chk("R1", "in_ready in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "ser_valid after reset", int'(ser_valid), 0);
    chk("R1", "eof after reset", int'(eof), 0);
    chk("R2", "idle without in_valid", int'(ser_valid), 0);
  endtask

  task automatic t_back_to_back;
    int m0, e0;
    m0 = mism; e0 = eof_bad;
    build(60, 11, 1'b0);
    build(20, 12, 1'b0);
    drive(60, 11, 1'b0, 0, 1'b0);
    drive(20, 12, 1'b0, 0, 1'b0);
    drain();
    chk("R10", "back-to-back bit mismatches", mism - m0, 0);
    chk("R10", "back-to-back eof", eof_bad - e0, 0);
    chk("R10", "leftover bits", exp_bits.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    run_frame("R5 short pad", 19, 1, 1'b0, 0, 1'b0, 1'b0);
    run_frame("R5 one pad byte", 59, 2, 1'b0, 0, 1'b0, 1'b0);
    run_frame("R5 no pad at minimum", 60, 3, 1'b0, 0, 1'b0, 1'b0);
    run_frame("R6 long frame", 100, 4, 1'b0, 0, 1'b0, 1'b0);
    run_frame("R7 crc off", 30, 5, 1'b1, 0, 1'b1, 1'b0);
    run_frame("R7 crc off short", 8, 6, 1'b1, 0, 1'b0, 1'b0);
    run_frame("R9 stalled source", 40, 7, 1'b0, 13, 1'b0, 1'b1);
    t_back_to_back();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule